// File: doc/BRIEF.md
# Timer with shared watchdog divider

This block combines an 8-bit event counter and an 8-bit watchdog counter that share one 8-bit divider. A control register decides which of the two counters owns the divider. When the timer owns it, the divider sits in front of the timer, so the timer and divider together count 16 bits. When the watchdog owns it, the divider sits behind the watchdog and thins out its overflows before they become a reset.

The timer counts either one-cycle instruction ticks or edges on an external pin. The pin is synchronized, and a control bit chooses whether rising or falling edges count. When the timer wraps from all ones to zero, it sets a pending flag. That flag, gated by an enable bit, drives an interrupt request. Software writes the timer, the control and the status registers over a simple write-only strobe interface. The registers are read back on dedicated output ports.

The watchdog counter runs on its own slow clock. A clear command from the main clock domain crosses into the watchdog domain as a toggle. Watchdog overflows cross back the same way, and the postscaling and the reset decision are made in the main domain. The watchdog clock must be several times slower than the main clock.

Top module: `rtw_timer_wdog`

## Requirements
- R1: After reset, the control output reads 0x0E, which assigns the divider to the watchdog with ratio code 110 (1:128). The timer, the pending flag, the interrupt request and the watchdog reset output are all 0.
- R2: A write with bus_sel 0 loads the timer, bus_sel 1 loads the control register and bus_sel 2 loads the status register. A timer load takes priority over a count in the same cycle.
- R3: Control layout. Bit 7 enables the interrupt. Bit 5 selects the count source: 0 counts instruction ticks and 1 counts pin edges. Bit 4 selects the pin edge: 1 counts falling edges and 0 counts rising edges. Bit 3 assigns the divider: 1 gives it to the watchdog and 0 gives it to the timer. Bits 2:0 hold a ratio code n, which divides by 2^(n+1).
- R4: While the divider belongs to the watchdog, the timer advances by one on every event from the selected source.
- R5: While the divider belongs to the timer, the timer advances once per 2^(n+1) source events. For example, 40 events at code 001 give 10, and 512 events at code 111 give 2.
- R6: In pin mode the pin passes through a two-flop synchronizer and only the selected edge counts. Instruction ticks have no effect in pin mode.
- R7: A timer write clears the divider when the divider belongs to the timer.
- R8: A write that changes control bit 3 clears the divider.
- R9: A timer wrap from 0xFF to 0x00 sets the pending flag, which is status bit 7. A status write stores its bit 7 into the flag. irq_o is the pending flag ANDed with control bit 7.
- R10: The watchdog counter overflows once every 256 watchdog clocks. While the watchdog owns the divider, a reset pulse follows every 2^(n+1) overflows. Otherwise a reset pulse follows every overflow.
- R11: A wdt_clear pulse clears the watchdog counter and, when the divider serves the watchdog, the divider too. Clearing more often than the overflow period prevents any reset.
- R12: No reset pulse is issued while wdt_enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main clock |
| rst_n | input | 1 | asynchronous active-low reset, both domains |
| cycle_tick | input | 1 | one-cycle instruction tick |
| ext_pin | input | 1 | asynchronous external count pin |
| bus_we | input | 1 | register write strobe |
| bus_sel | input | 2 | register select: 0 timer, 1 control, 2 status |
| bus_wdata | input | CNT_W | write data |
| wdt_clk | input | 1 | slow watchdog clock |
| wdt_enable | input | 1 | fuse-level watchdog enable |
| wdt_clear | input | 1 | one-cycle clear command, main domain |
| timer_o | output | CNT_W | timer value |
| ctrl_o | output | 8 | control register value |
| pend_o | output | 1 | rollover pending flag |
| irq_o | output | 1 | interrupt request |
| wdt_reset_o | output | 1 | one-cycle watchdog reset pulse |

## Verification
The hardest case to reach is the divider's hidden count: the divider cannot be read. The stimulus leaves it partly filled, then issues a timer write or a double flip of the assignment bit. It then applies just fewer events than one divide period and checks that the timer has not moved, which can only happen if the count was wiped.

Watchdog behaviour depends on the phase of a free-running counter in another clock domain. Each watchdog scenario therefore begins with two clear commands. It then counts reset pulses inside time windows placed well clear of the predicted overflow instants.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
   typedef enum logic [1:0] {
      REG_TIMER = 2'd0,
      REG_CTRL  = 2'd1,
      REG_STAT  = 2'd2
   } reg_sel_e;

   localparam int RATIO_W  = 3;
   localparam int PEND_BIT = 7;

   typedef struct packed {
      logic               irq_en;
      logic               spare;
      logic               ext_src;
      logic               fall_edge;
      logic               to_wdog;
      logic [RATIO_W-1:0] ratio;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{irq_en: 1'b0, spare: 1'b0, ext_src: 1'b0,
                                    fall_edge: 1'b0, to_wdog: 1'b1, ratio: 3'b110};
endpackage

// File: rtl/rtw_bit_sync.sv
module rtw_bit_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtw_bit_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d_i};
   end

   assign q_o = ff[STAGES-1];
endmodule

// File: rtl/rtw_pin_edge.sv
module rtw_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic fall_sel_i,
   output logic edge_o
);
   logic pin_s, pin_prev, rise, fall;

   rtw_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   assign rise   = pin_s & ~pin_prev;
   assign fall   = ~pin_s & pin_prev;
   assign edge_o = fall_sel_i ? fall : rise;

   // R6
   edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/rtw_share_div.sv
module rtw_share_div #(
   parameter int DIV_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   generate
      if ((1 << SEL_W) < DIV_W) begin : g_bad_sel
         $error("rtw_share_div: SEL_W cannot address every divider bit");
      end
   endgenerate

   logic [DIV_W-1:0] cnt, mask;

   generate
      for (genvar i = 0; i < DIV_W; i++) begin : g_mask
         assign mask[i] = (i <= int'(sel_i));
      end
   endgenerate

   assign tick_o = en_i && ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr_i) cnt <= '0;
      else if (en_i)  cnt <= cnt + DIV_W'(1);
   end

   // R7 / R8
   div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));
   // R5
   div_tick_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> en_i);
endmodule

// File: rtl/rtw_wdog_core.sv
module rtw_wdog_core #(
   parameter int WDT_W  = 8,
   parameter int STAGES = 2
) (
   input  logic wclk,
   input  logic rst_n,
   input  logic clr_tgl_i,
   output logic ovf_tgl_o
);
   logic             clr_s, clr_prev, clr_evt;
   logic [WDT_W-1:0] cnt;

   rtw_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_clr_sync (
      .clk(wclk), .rst_n(rst_n), .d_i(clr_tgl_i), .q_o(clr_s)
   );

   assign clr_evt = clr_s ^ clr_prev;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         clr_prev  <= 1'b0;
         cnt       <= '0;
         ovf_tgl_o <= 1'b0;
      end else begin
         clr_prev <= clr_s;
         if (clr_evt) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + WDT_W'(1);
            if (cnt == '1) ovf_tgl_o <= ~ovf_tgl_o;
         end
      end
   end

   // R11
   wdt_clear_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      clr_evt |=> (cnt == '0));
   // R10
   wdt_wrap_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (!clr_evt && cnt == '1) |=> (cnt == '0) && (ovf_tgl_o != $past(ovf_tgl_o)));
endmodule

// File: rtl/rtw_timer_wdog.sv
module rtw_timer_wdog
   import rtw_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DIV_W       = 8,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cycle_tick,
   input  logic             ext_pin,
   input  logic             bus_we,
   input  logic [1:0]       bus_sel,
   input  logic [CNT_W-1:0] bus_wdata,
   input  logic             wdt_clk,
   input  logic             wdt_enable,
   input  logic             wdt_clear,
   output logic [CNT_W-1:0] timer_o,
   output logic [7:0]       ctrl_o,
   output logic             pend_o,
   output logic             irq_o,
   output logic             wdt_reset_o
);
   localparam int SEL_W = $clog2(DIV_W);

   generate
      if (CNT_W < 8) begin : g_bad_cnt
         $error("rtw_timer_wdog: CNT_W must hold the 8-bit control word");
      end
      if (SEL_W != RATIO_W) begin : g_bad_div
         $error("rtw_timer_wdog: DIV_W must match the ratio field");
      end
      if (WDT_W < 2) begin : g_bad_wdt
         $error("rtw_timer_wdog: WDT_W too small");
      end
   endgenerate

   ctrl_t            ctrl_q, ctrl_new;
   logic [CNT_W-1:0] timer_q;
   logic             pend_q, wdt_rst_q, clr_tgl, ovf_tgl, ovf_s, ovf_prev;
   logic             wr_timer, wr_ctrl, wr_stat, psa, psa_chg;
   logic             pin_edge, src_tick, wdt_evt;
   logic             div_en, div_clr, div_tick;
   logic             timer_inc, rollover, wdt_fire;

   assign ctrl_new = ctrl_t'(bus_wdata[7:0]);
   assign wr_timer = bus_we && (bus_sel == REG_TIMER);
   assign wr_ctrl  = bus_we && (bus_sel == REG_CTRL);
   assign wr_stat  = bus_we && (bus_sel == REG_STAT);
   assign psa      = ctrl_q.to_wdog;
   assign psa_chg  = wr_ctrl && (ctrl_new.to_wdog != psa);

   rtw_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin),
      .fall_sel_i(ctrl_q.fall_edge), .edge_o(pin_edge)
   );

   assign src_tick = ctrl_q.ext_src ? pin_edge : cycle_tick;

   rtw_wdog_core #(.WDT_W(WDT_W), .STAGES(SYNC_STAGES)) u_wdog (
      .wclk(wdt_clk), .rst_n(rst_n), .clr_tgl_i(clr_tgl), .ovf_tgl_o(ovf_tgl)
   );

   rtw_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ovf_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ovf_tgl), .q_o(ovf_s)
   );

   assign wdt_evt = ovf_s ^ ovf_prev;

   assign div_en  = psa ? wdt_evt : src_tick;
   assign div_clr = psa_chg || (!psa && wr_timer) || (psa && wdt_clear);

   rtw_share_div #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr_i(div_clr), .en_i(div_en),
      .sel_i(ctrl_q.ratio), .tick_o(div_tick)
   );

   assign timer_inc = psa ? src_tick : div_tick;
   assign wdt_fire  = psa ? div_tick : wdt_evt;
   assign rollover  = timer_inc && !wr_timer && (timer_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RESET;
         timer_q   <= '0;
         pend_q    <= 1'b0;
         wdt_rst_q <= 1'b0;
         clr_tgl   <= 1'b0;
         ovf_prev  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_new;
         if (wr_timer)       timer_q <= bus_wdata;
         else if (timer_inc) timer_q <= timer_q + CNT_W'(1);
         if (rollover)     pend_q <= 1'b1;
         else if (wr_stat) pend_q <= bus_wdata[PEND_BIT];
         wdt_rst_q <= wdt_fire & wdt_enable;
         if (wdt_clear) clr_tgl <= ~clr_tgl;
         ovf_prev <= ovf_s;
      end
   end

   assign timer_o     = timer_q;
   assign ctrl_o      = ctrl_q;
   assign pend_o      = pend_q;
   assign irq_o       = pend_q & ctrl_q.irq_en;
   assign wdt_reset_o = wdt_rst_q;

   // R2
   timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_timer |=> (timer_o == $past(bus_wdata)));
   // R4
   raw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_tick && !ctrl_q.ext_src && psa && !wr_timer && !wr_ctrl)
      |=> (timer_o == $past(timer_o) + CNT_W'(1)));
   // R9
   rollover_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |=> pend_o);
   // R10
   direct_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!psa && wdt_evt && wdt_enable) |=> wdt_reset_o);
   // R12
   wdt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_enable |=> !wdt_reset_o);
endmodule

// File: tb/sim_rtw_timer_wdog.sv
module sim_rtw_timer_wdog;
   localparam int CLK_PERIOD = 10;
   localparam int WCLK_PERIOD = 40;

   logic       clk = 0, wdt_clk = 0, rst_n = 0;
   logic       cycle_tick = 0, ext_pin = 0, bus_we = 0;
   logic [1:0] bus_sel = 0;
   logic [7:0] bus_wdata = 0;
   logic       wdt_enable = 0, wdt_clear = 0;
   logic [7:0] timer_o, ctrl_o;
   logic       pend_o, irq_o, wdt_reset_o;

   int checks = 0, fails = 0, rst_pulses = 0, pulse_base = 0;
   bit done = 0;

   string q_req[$];
   int    q_sig[$];
   int    q_exp[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(WCLK_PERIOD/2) wdt_clk = ~wdt_clk;

   rtw_timer_wdog u0 (
      .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .ext_pin(ext_pin),
      .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .wdt_clk(wdt_clk), .wdt_enable(wdt_enable), .wdt_clear(wdt_clear),
      .timer_o(timer_o), .ctrl_o(ctrl_o), .pend_o(pend_o), .irq_o(irq_o),
      .wdt_reset_o(wdt_reset_o)
   );

   always @(posedge clk) if (wdt_reset_o) rst_pulses++;

   function automatic int actual(int s);
      case (s)
         0: return int'(timer_o);
         1: return int'(ctrl_o);
         2: return int'(pend_o);
         3: return int'(irq_o);
         4: return rst_pulses - pulse_base;
         default: return int'(wdt_reset_o);
      endcase
   endfunction

   // monitor: pops expected items and compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk); #1;
         while (q_req.size() > 0) begin
            string r; int s; int e; int a;
            r = q_req.pop_front(); s = q_sig.pop_front(); e = q_exp.pop_front();
            a = actual(s);
            checks++;
            if (a !== e) begin
               fails++;
               $display("FAIL %s signal %0d: actual 0x%0h expected 0x%0h", r, s, a, e);
            end
         end
      end
   end

   task automatic expect_item(string r, int s, int e);
      q_req.push_back(r); q_sig.push_back(s); q_exp.push_back(e);
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [1:0] sel, logic [7:0] d);
      @(negedge clk); bus_we = 1; bus_sel = sel; bus_wdata = d;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cycle_tick = 1;
         @(negedge clk); cycle_tick = 0;
      end
   endtask

   task automatic pin_set(logic v);
      @(negedge clk); ext_pin = v;
      idle(4);
   endtask

   task automatic clear_pulse();
      @(negedge clk); wdt_clear = 1;
      @(negedge clk); wdt_clear = 0;
   endtask

   task automatic wdt_arm();
      clear_pulse(); idle(50); clear_pulse(); idle(2);
      pulse_base = rst_pulses;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3); rst_n = 1; idle(2);
      // R1 reset state
      expect_item("R1", 0, 0); expect_item("R1", 1, 8'h0E);
      expect_item("R1", 2, 0); expect_item("R1", 3, 0); expect_item("R1", 5, 0);
      settle();

      // R2 / R3 / R4: raw instruction ticks, divider on watchdog
      bus_write(1, 8'h08); bus_write(0, 8'h00);
      expect_item("R2", 1, 8'h08); settle();
      ticks(37); idle(1);
      expect_item("R4", 0, 37); settle();
      bus_write(0, 8'h5A); expect_item("R2", 0, 8'h5A); settle();

      // R5 prescale 1:4 and 1:256
      bus_write(1, 8'h01); bus_write(0, 8'h00);
      ticks(40); idle(1); expect_item("R5", 0, 10); settle();
      bus_write(1, 8'h07); bus_write(0, 8'h00);
      ticks(512); idle(1); expect_item("R5", 0, 2); settle();

      // R7 timer write wipes a partly filled divider (1:8)
      bus_write(1, 8'h02); bus_write(0, 8'h00);
      ticks(5); bus_write(0, 8'h00);
      ticks(7); idle(1); expect_item("R7", 0, 0); settle();
      ticks(1); idle(1); expect_item("R7", 0, 1); settle();

      // R8 assignment flip wipes divider (1:4)
      wdt_arm();
      bus_write(1, 8'h01); bus_write(0, 8'h00);
      ticks(3); bus_write(1, 8'h09); bus_write(1, 8'h01);
      ticks(3); idle(1); expect_item("R8", 0, 0); settle();
      ticks(1); idle(1); expect_item("R8", 0, 1); settle();

      // R6 pin edges, rising then falling
      bus_write(1, 8'h28); bus_write(0, 8'h00);
      for (int i = 0; i < 5; i++) begin pin_set(1); pin_set(0); end
      expect_item("R6", 0, 5); settle();
      ticks(10); idle(1); expect_item("R6", 0, 5); settle();
      bus_write(1, 8'h38); bus_write(0, 8'h00);
      pin_set(1); expect_item("R6", 0, 0); settle();
      pin_set(0); expect_item("R6", 0, 1); settle();

      // R9 rollover, pending and interrupt
      bus_write(1, 8'h08); bus_write(0, 8'hFE);
      ticks(1); idle(1); expect_item("R9", 0, 8'hFF); expect_item("R9", 2, 0); settle();
      ticks(1); idle(1);
      expect_item("R9", 0, 0); expect_item("R9", 2, 1); expect_item("R9", 3, 0); settle();
      bus_write(1, 8'h88); expect_item("R9", 3, 1); settle();
      bus_write(2, 8'h00); expect_item("R9", 2, 0); expect_item("R9", 3, 0); settle();

      // R10 postscale 1:2 on watchdog overflow
      bus_write(1, 8'h08); wdt_enable = 1; wdt_arm();
      idle(1500); expect_item("R10", 4, 0); settle();
      idle(1000); expect_item("R10", 4, 1); settle();

      // R12 disabled watchdog never fires
      wdt_enable = 0; wdt_arm();
      idle(2500); expect_item("R12", 4, 0); settle();

      // R11 regular clearing prevents reset
      wdt_enable = 1; wdt_arm();
      for (int i = 0; i < 5; i++) begin idle(600); clear_pulse(); end
      expect_item("R11", 4, 0); settle();

      // R10 divider on timer: every overflow fires
      bus_write(1, 8'h00); wdt_arm();
      idle(1500); expect_item("R10", 4, 1); settle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule